// File: doc/BRIEF.md
# CAN Standby Wakeup Detector

This block holds the digital mode control and wakeup qualification of a high-speed CAN transceiver. A mode-select input chooses between normal operation and a low-power standby state. In normal operation the transmitter and receiver enables are high and the receive-data output follows the sampled bus level: low when the bus is dominant, high when it is recessive.

In standby both enables are low and the receive output stays high until the bus has been dominant for more than a programmable number of clock cycles. The output then goes low to tell the controller that a wakeup was seen. It goes high again when the bus returns to recessive. Standby is left only when the mode-select input goes low. A parameter selects between two wakeup variants. In the unconditioned variant, a dominant level that is already on the bus when standby begins can qualify at once. In the conditioned variant, the bus must first be seen recessive in standby, so a bus that is stuck dominant cannot keep a sleeping network awake.

Top module: `can_wake_ctrl`

## Requirements
- R1: A high `stby_req` selects standby, where `tx_en` and `rx_en` are both 0. A low `stby_req` selects normal operation, where both are 1.
- R2: In normal operation `rxd` is the inverse of `bus_dom`, combinationally (bus_dom=1 gives rxd=0).
- R3: `stby_req` passes through two flip-flops. A change made before clock edge k shows on `tx_en`/`rx_en` after edge k+1 and not after edge k.
- R4: In standby, `rxd` is 1 in every cycle after a clock edge at which `bus_dom` was sampled 0.
- R5: In standby with wakeup armed, `rxd` goes to 0 after the edge that samples the (FILT_CYC+1)-th consecutive dominant sample. It stays 0 while the bus stays dominant.
- R6: A dominant run of at most FILT_CYC samples in standby leaves `rxd` at 1 throughout, and the next run counts again from zero.
- R7: With UNCOND=1, a dominant level present when standby takes effect gives `rxd`=1 at first. After FILT_CYC+1 standby clock edges with the bus still dominant, `rxd` becomes 0.
- R8: With UNCOND=0, a dominant level present when standby takes effect never drives `rxd` low. After one recessive sample, a later dominant run longer than FILT_CYC does drive `rxd` low.
- R9: A wakeup does not change the mode. `tx_en` stays 0, and every later dominant run longer than FILT_CYC is echoed as a low on `rxd`.
- R10: While reset is asserted the block is in standby: `tx_en`=0, `rx_en`=0, `rxd`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stby_req | input | 1 | Mode select, asynchronous: 1 = standby, 0 = normal |
| bus_dom | input | 1 | Sampled bus state from the receiver: 1 = dominant |
| rxd | output | 1 | Receive data / wakeup indication toward the controller |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Normal receiver enable |

## Verification
The hardest case to reach is the wakeup-variant difference. It shows only when the mode switches while the bus is already dominant, and only across the two-cycle synchronizer delay. The bench holds the bus dominant in normal operation, raises the mode input, and steps edge by edge through the synchronizer. An unconditioned and a conditioned instance run side by side on the same stimulus. The bench then sweeps dominant run lengths from one sample to beyond the filter limit and predicts the exact edge of each output change from the run length.

// File: rtl/can_wake_pkg.sv
package can_wake_pkg;
  typedef enum logic {
    MODE_NORMAL  = 1'b0,
    MODE_STANDBY = 1'b1
  } cw_mode_e;

  localparam int unsigned CW_SYNC_STAGES = 2;
endpackage

// File: rtl/cw_reset_sync.sv
module cw_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/cw_mode_sync.sv
module cw_mode_sync
  import can_wake_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_async,
  output cw_mode_e mode
);
  logic [CW_SYNC_STAGES-1:0] chain_q;
  logic [CW_SYNC_STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CW_SYNC_STAGES-2:0], req_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign mode = chain_q[CW_SYNC_STAGES-1] ? MODE_STANDBY : MODE_NORMAL;
endmodule

// File: rtl/cw_wake_arm.sv
module cw_wake_arm #(
  parameter bit UNCOND = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_stby,
  input  logic bus_dom,
  output logic armed
);
  generate
    if (UNCOND) begin : g_uncond
      assign armed = 1'b1;
    end else begin : g_cond
      logic arm_q;
      logic arm_d;
      logic arm_en;

      always_comb begin
        arm_en = !in_stby || !bus_dom;
        arm_d  = in_stby;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      arm_q <= 1'b0;
        else if (arm_en) arm_q <= arm_d;
      end

      assign armed = arm_q;
    end
  endgenerate
endmodule

// File: rtl/cw_dom_filter.sv
module cw_dom_filter #(
  parameter int unsigned FILT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_stby,
  input  logic armed,
  input  logic bus_dom,
  output logic wake
);
  localparam int unsigned CW = (FILT_CYC < 1) ? 1 : $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FILT_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wake_q, wake_d;
  logic          counting;

  always_comb begin
    counting = in_stby && armed && bus_dom;
    if (!counting)           cnt_d = '0;
    else if (cnt_q == LIMIT) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
    wake_d = counting && (wake_q || (cnt_q == LIMIT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wake_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wake_q <= wake_d;
    end
  end

  assign wake = wake_q;
endmodule

// File: rtl/can_wake_ctrl.sv
module can_wake_ctrl
  import can_wake_pkg::*;
#(
  parameter int unsigned FILT_CYC = 4,
  parameter bit          UNCOND   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stby_req,
  input  logic bus_dom,
  output logic rxd,
  output logic tx_en,
  output logic rx_en
);
  logic     rst_int;
  cw_mode_e mode;
  logic     in_stby;
  logic     armed;
  logic     wake;

  cw_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int)
  );

  cw_mode_sync u_mode (
    .clk       (clk),
    .rst_n     (rst_int),
    .req_async (stby_req),
    .mode      (mode)
  );

  assign in_stby = (mode == MODE_STANDBY);

  cw_wake_arm #(.UNCOND(UNCOND)) u_arm (
    .clk     (clk),
    .rst_n   (rst_int),
    .in_stby (in_stby),
    .bus_dom (bus_dom),
    .armed   (armed)
  );

  cw_dom_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk     (clk),
    .rst_n   (rst_int),
    .in_stby (in_stby),
    .armed   (armed),
    .bus_dom (bus_dom),
    .wake    (wake)
  );

  always_comb begin
    tx_en = !in_stby;
    rx_en = !in_stby;
    rxd   = in_stby ? !wake : !bus_dom;
  end
endmodule

// File: rtl/can_wake_chk.sv
module can_wake_chk (
  input logic clk,
  input logic rst_n,
  input logic stby_req,
  input logic bus_dom,
  input logic rxd,
  input logic tx_en,
  input logic rx_en
);
  logic [1:0] age_q;
  logic       live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assign live = (age_q == 2'd3);

  assert_mode_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (tx_en == !$past(stby_req, 2)));

  assert_enables_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (rx_en == !$past(stby_req, 2)));

  assert_normal_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && tx_en) |-> (rxd == !bus_dom));

  assert_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !tx_en && $past(!bus_dom)) |-> rxd);

  assert_wake_needs_dom_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !tx_en && $past(!tx_en) && $fell(rxd)) |-> $past(bus_dom));
endmodule

bind can_wake_ctrl can_wake_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_int),
  .stby_req (stby_req),
  .bus_dom  (bus_dom),
  .rxd      (rxd),
  .tx_en    (tx_en),
  .rx_en    (rx_en)
);

// File: tb/sim_can_wake_ctrl.sv
module sim_can_wake_ctrl;
  localparam int CLK_P = 10;
  localparam int FILT  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stby_req = 1'b1;
  logic bus_dom = 1'b0;
  logic rxd0, tx0, rx0;
  logic rxd1, tx1, rx1;
  int   n_chk = 0;
  int   n_fail = 0;
  int   cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  can_wake_ctrl #(.FILT_CYC(FILT), .UNCOND(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .bus_dom(bus_dom),
    .rxd(rxd0), .tx_en(tx0), .rx_en(rx0));

  can_wake_ctrl #(.FILT_CYC(FILT), .UNCOND(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .bus_dom(bus_dom),
    .rxd(rxd1), .tx_en(tx1), .rx_en(rx1));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: got %b expected %b", req, cyc, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    cyc++;
    #(CLK_P/2);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    #(CLK_P/2);
    // R10: reset state
    step();
    chk("R10 tx_en", tx0, 1'b0);
    chk("R10 rx_en", rx0, 1'b0);
    chk("R10 rxd", rxd0, 1'b1);
    chk("R10 rxd cond", rxd1, 1'b1);
    rst_n = 1'b1;
    repeat (4) step();

    // R3 / R1: leave standby, two-edge latency
    stby_req = 1'b0;
    step();
    chk("R3 first edge", tx0, 1'b0);
    step();
    chk("R3 second edge", tx0, 1'b1);
    chk("R1 rx_en normal", rx0, 1'b1);
    chk("R1 tx_en normal cond", tx1, 1'b1);

    // R2: normal copy sweep
    for (int i = 0; i < 16; i++) begin
      bus_dom = ((i * 5) % 3) == 0;
      #1;
      chk("R2 rxd0", rxd0, !bus_dom);
      chk("R2 rxd1", rxd1, !bus_dom);
      step();
    end

    // R1: enter standby with recessive bus
    bus_dom = 1'b0;
    stby_req = 1'b1;
    step();
    step();
    chk("R1 tx_en standby", tx0, 1'b0);
    chk("R1 rx_en standby", rx1, 1'b0);
    step();
    chk("R4 idle rxd", rxd1, 1'b1);

    // R5 / R6 / R9: sweep run lengths
    for (int len = 1; len <= FILT + 3; len++) begin
      bus_dom = 1'b1;
      for (int k = 1; k <= len; k++) begin
        step();
        chk("R5 R6 rxd0", rxd0, !(k >= FILT + 1));
        chk("R5 R6 rxd1", rxd1, !(k >= FILT + 1));
        chk("R9 tx_en", tx0, 1'b0);
      end
      bus_dom = 1'b0;
      step();
      chk("R4 release rxd0", rxd0, 1'b1);
      chk("R4 release rxd1", rxd1, 1'b1);
      step();
    end

    // Back to normal with the bus dominant, then standby while dominant
    stby_req = 1'b0;
    step();
    step();
    bus_dom = 1'b1;
    #1;
    chk("R2 dominant normal", rxd0, 1'b0);
    step();
    stby_req = 1'b1;
    step();
    chk("R3 still normal", tx0, 1'b1);
    chk("R2 still copy", rxd1, 1'b0);
    step();
    chk("R7 glitch high", rxd0, 1'b1);
    chk("R8 entry high", rxd1, 1'b1);
    for (int k = 1; k <= FILT + 3; k++) begin
      step();
      chk("R7 uncond wake", rxd0, !(k >= FILT + 1));
      chk("R8 cond blocked", rxd1, 1'b1);
    end
    bus_dom = 1'b0;
    step();
    chk("R4 rxd0", rxd0, 1'b1);
    chk("R4 rxd1", rxd1, 1'b1);
    bus_dom = 1'b1;
    for (int k = 1; k <= FILT + 2; k++) begin
      step();
      chk("R8 later wake", rxd1, !(k >= FILT + 1));
      chk("R9 echo", rxd0, !(k >= FILT + 1));
      chk("R9 stays standby", tx1, 1'b0);
    end
    bus_dom = 1'b0;
    step();
    chk("R4 final", rxd1, 1'b1);
    finish_run();
  end
endmodule